// File: doc/BRIEF.md
# Dual Countdown Timer Register Window

This block puts two independent countdown timers behind one 4 KB synchronous register port. The byte address picks the target. The low two 32-byte windows each hold one timer's register set. A fixed eight-entry identification table sits at the top of the window. Every other location reads as zero and ignores writes. Reads are combinational from the address. Writes take effect on the rising clock edge.

Each timer has its own tick-enable input, so the two can count at unrelated base rates. Each timer can also slow its tick by 16 or 256 with a prescaler. The timers' masked interrupt lines are combined into one interrupt output.

Top module: `dual_timer_win`

## Requirements
- R1: Byte addresses 0x00–0x1F reach timer 0, with the address used as its local offset.
- R2: Byte addresses 0x20–0x3F reach timer 1, with the local offset equal to the address minus 0x20.
- R3: Reads at 0xFE0–0xFFC return an identification byte, zero-extended, chosen by (address − 0xFE0)/4 from the list 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R4: Reads at 0xF00, 0xF04 and every other address outside the timer windows and the identification table return 0.
- R5: `irq_o` is high exactly when at least one timer has its raw flag set while its control bit 5 (interrupt enable) is set.
- R6: A write to any address at or above 0x40 changes no timer register and no identification byte.
- R7: A timer steps only on cycles where its own `tick_i` bit is high. The prescaler selected by control bits [3:2] passes every tick for 0 or 3, every 16th tick for 1, and every 256th tick for 2. A control write clears the prescaler.
- R8: The local word map is as follows. Offset 0x00 reads the reload value, and a write sets both the reload value and the count. Offset 0x04 reads the count, and writes to it are ignored. Offset 0x08 is the control byte. A write to 0x0C clears the raw flag. Offset 0x10 reads the raw flag. Offset 0x14 reads the raw flag ANDed with the interrupt enable. A write to 0x18 sets only the reload value, and a read returns it. Offsets 0x0C and 0x1C read 0.
- R9: The control bits are: bit 7 enable, bit 6 periodic, bit 1 for 32-bit width (16-bit when clear), and bit 0 one-shot, which takes precedence over periodic. On a step, a nonzero count decrements. A step from 1 to 0 sets the raw flag, and this takes priority over a clear in the same cycle. At zero, a one-shot timer holds, a periodic timer loads the reload value, and a free-running timer wraps to 0xFFFF or 0xFFFFFFFF.
- R10: After reset, each timer's control reads 0x20, its reload reads 0, its count reads 0xFFFF, its raw flag reads 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address inside the window |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| tick_i | input | 2 | Per-timer tick enable, bit n for timer n |
| irq_o | output | 1 | OR of the two masked timer interrupts |

## Verification
Some properties are checked by assertions on every cycle. Reads outside the timer windows return zero, and reads of the identification table have zero upper bits. Writes above the timer windows leave every control byte and reload value unchanged. The interrupt output is never high without a raw flag set. A timer's count stays put when there is no tick for it and no write to it. An interrupt clear without a coincident tick drops the flag.

Other behaviour can only be shown by the bench's scenarios and its cycle-accurate model. This covers the exact identification values and the per-window offset routing. It also covers prescaler ratios, reload versus wrap versus hold at zero, and the priority of expiry over clear.

// File: rtl/dtw_pkg.sv
`timescale 1ns/1ps
package dtw_pkg;
  localparam int CTRL_W   = 8;
  localparam int B_ONESHOT = 0;
  localparam int B_WIDE   = 1;
  localparam int B_PRE_LO = 2;
  localparam int B_PRE_HI = 3;
  localparam int B_IE     = 5;
  localparam int B_PER    = 6;
  localparam int B_EN     = 7;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h20;

  localparam int WIN_SH = 5;  // 32-byte window per timer

  // word index inside a timer window
  localparam logic [2:0] OFF_LOAD = 3'd0;
  localparam logic [2:0] OFF_CNT  = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam logic [2:0] OFF_ICLR = 3'd3;
  localparam logic [2:0] OFF_RAW  = 3'd4;
  localparam logic [2:0] OFF_MSK  = 3'd5;
  localparam logic [2:0] OFF_BGL  = 3'd6;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h04;
      3'd1: id_byte = 8'h18;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dtw_prescale.sv
`timescale 1ns/1ps
module dtw_prescale #(
  parameter int PSC_W  = 8,
  parameter int SH_MID = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [1:0] div_i,
  output logic       fire_o
);
  localparam logic [PSC_W-1:0] LIM_MID = PSC_W'((1 << SH_MID) - 1);
  localparam logic [PSC_W-1:0] LIM_HI  = '1;

  logic [PSC_W-1:0] psc_q, lim;
  logic             wrap;

  always_comb begin
    case (div_i)
      2'd1:    lim = LIM_MID;
      2'd2:    lim = LIM_HI;
      default: lim = '0;
    endcase
  end

  assign wrap   = (psc_q == lim);
  assign fire_o = en_i & tick_i & ~clr_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             psc_q <= '0;
    else if (clr_i)          psc_q <= '0;
    else if (en_i && tick_i) psc_q <= wrap ? '0 : psc_q + 1'b1;
  end
endmodule

// File: rtl/dtw_timer.sv
`timescale 1ns/1ps
module dtw_timer
  import dtw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [2:0]        off_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              raw_o,
  output logic              irq_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DW-1:0]     load_o,
  output logic [DW-1:0]     cnt_o
);
  localparam logic [DW-1:0] HALF_MASK = {{(DW/2){1'b0}}, {(DW/2){1'b1}}};

  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     load_q, cnt_q, cnt_eff, cnt_nxt;
  logic              raw_q, fire, ctrl_wr, at_zero, at_one;

  assign ctrl_wr = wr_i && (off_i == OFF_CTRL);
  assign cnt_eff = ctrl_q[B_WIDE] ? cnt_q : (cnt_q & HALF_MASK);
  assign at_zero = (cnt_eff == '0);
  assign at_one  = (cnt_eff == DW'(1));

  dtw_prescale #(.PSC_W(8), .SH_MID(4)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .en_i   (ctrl_q[B_EN]),
    .clr_i  (ctrl_wr),
    .div_i  (ctrl_q[B_PRE_HI:B_PRE_LO]),
    .fire_o (fire)
  );

  always_comb begin
    cnt_nxt = cnt_q;
    if (wr_i && off_i == OFF_LOAD) begin
      cnt_nxt = wdata_i;
    end else if (fire) begin
      if (!at_zero)                cnt_nxt = cnt_eff - 1'b1;
      else if (ctrl_q[B_ONESHOT])  cnt_nxt = cnt_eff;
      else if (ctrl_q[B_PER])      cnt_nxt = load_q;
      else                         cnt_nxt = ctrl_q[B_WIDE] ? '1 : HALF_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      load_q <= '0;
      cnt_q  <= '1;
      raw_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (ctrl_wr) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr_i && (off_i == OFF_LOAD || off_i == OFF_BGL)) load_q <= wdata_i;
      // expiry wins over a same-cycle clear
      if (fire && at_one)                     raw_q <= 1'b1;
      else if (wr_i && off_i == OFF_ICLR)     raw_q <= 1'b0;
    end
  end

  always_comb begin
    case (off_i)
      OFF_LOAD, OFF_BGL: rdata_o = load_q;
      OFF_CNT:           rdata_o = cnt_eff;
      OFF_CTRL:          rdata_o = DW'(ctrl_q);
      OFF_RAW:           rdata_o = DW'(raw_q);
      OFF_MSK:           rdata_o = DW'(raw_q & ctrl_q[B_IE]);
      default:           rdata_o = '0;
    endcase
  end

  assign raw_o  = raw_q;
  assign irq_o  = raw_q & ctrl_q[B_IE];
  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign cnt_o  = cnt_eff;
endmodule

// File: rtl/dtw_decode.sv
`timescale 1ns/1ps
module dtw_decode
  import dtw_pkg::*;
#(
  parameter int N_TMR = 2,
  parameter int AW    = 12
) (
  input  logic [AW-1:0]    addr_i,
  output logic [N_TMR-1:0] tmr_hit_o,
  output logic             id_hit_o,
  output logic [2:0]       word_o
);
  localparam int TOP_W = AW - WIN_SH;

  logic [TOP_W-1:0] win;
  logic             unused_lsb;

  assign win        = addr_i[AW-1:WIN_SH];
  assign word_o     = addr_i[WIN_SH-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign id_hit_o   = (win == '1);

  for (genvar i = 0; i < N_TMR; i++) begin : g_hit
    assign tmr_hit_o[i] = (win == TOP_W'(i));
  end
endmodule

// File: rtl/dtw_id_rom.sv
`timescale 1ns/1ps
module dtw_id_rom
  import dtw_pkg::*;
(
  input  logic [2:0] idx_i,
  output logic [7:0] val_o
);
  assign val_o = id_byte(idx_i);
endmodule

// File: rtl/dual_timer_win.sv
`timescale 1ns/1ps
module dual_timer_win
  import dtw_pkg::*;
#(
  parameter int N_TMR = 2,
  parameter int DW    = 32,
  parameter int AW    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_TMR-1:0] tick_i,
  output logic             irq_o
);
  logic [N_TMR-1:0]             tmr_hit, raw_v, irq_v;
  logic                         id_hit;
  logic [2:0]                   word;
  logic [7:0]                   id_val;
  logic [N_TMR-1:0][DW-1:0]     t_rdata, load_v, cnt_v;
  logic [N_TMR-1:0][CTRL_W-1:0] ctrl_v;

  dtw_decode #(.N_TMR(N_TMR), .AW(AW)) u_dec (
    .addr_i    (addr_i),
    .tmr_hit_o (tmr_hit),
    .id_hit_o  (id_hit),
    .word_o    (word)
  );

  dtw_id_rom u_id (
    .idx_i (word),
    .val_o (id_val)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    dtw_timer #(.DW(DW)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i[i]),
      .wr_i    (wr_en_i & tmr_hit[i]),
      .off_i   (word),
      .wdata_i (wdata_i),
      .rdata_o (t_rdata[i]),
      .raw_o   (raw_v[i]),
      .irq_o   (irq_v[i]),
      .ctrl_o  (ctrl_v[i]),
      .load_o  (load_v[i]),
      .cnt_o   (cnt_v[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_TMR; i++)
      if (tmr_hit[i]) rdata_o = rdata_o | t_rdata[i];
    if (id_hit) rdata_o = rdata_o | DW'(id_val);
  end

  assign irq_o = |irq_v;
endmodule

// File: rtl/dual_timer_win_chk.sv
`timescale 1ns/1ps
module dual_timer_win_chk #(
  parameter int N_TMR = 2,
  parameter int DW    = 32,
  parameter int AW    = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [AW-1:0]            addr_i,
  input logic                     wr_en_i,
  input logic [DW-1:0]            rdata_o,
  input logic                     irq_o,
  input logic [N_TMR-1:0]         tick_i,
  input logic [N_TMR-1:0][7:0]    ctrl_v,
  input logic [N_TMR-1:0][DW-1:0] load_v,
  input logic [N_TMR-1:0][DW-1:0] cnt_v,
  input logic [N_TMR-1:0]         raw_v
);
  localparam logic [AW-1:0] TMR_END = AW'(N_TMR * 32);
  localparam logic [AW-1:0] ID_BASE = AW'(12'hFE0);

  p_id_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= ID_BASE) |-> (rdata_o[DW-1:8] == '0));

  p_unmapped_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= TMR_END && addr_i < ID_BASE) |-> (rdata_o == '0));

  p_irq_has_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw_v != '0));

  p_wr_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i >= TMR_END) |=> ($stable(ctrl_v) && $stable(load_v)));

  for (genvar i = 0; i < N_TMR; i++) begin : g_p
    p_tick_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i[i] && !(wr_en_i && addr_i[AW-1:5] == (AW-5)'(i))) |=> $stable(cnt_v[i]));

    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == AW'(i * 32 + 12) && !tick_i[i]) |=> !raw_v[i]);
  end
endmodule

bind dual_timer_win dual_timer_win_chk #(.N_TMR(N_TMR), .DW(DW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .tick_i  (tick_i),
  .ctrl_v  (ctrl_v),
  .load_v  (load_v),
  .cnt_v   (cnt_v),
  .raw_v   (raw_v)
);

// File: tb/dual_timer_win_bench.sv
`timescale 1ns/1ps
module dual_timer_win_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  tick_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  dual_timer_win u_dual_timer_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i), .irq_o(irq_o)
  );

  always #10 clk_i = ~clk_i;

  // behavioural reference
  logic [31:0] m_load [2];
  logic [31:0] m_cnt  [2];
  logic [7:0]  m_ctrl [2];
  logic        m_raw  [2];
  int          m_psc  [2];
  logic [7:0]  ids [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  function automatic logic [31:0] m_eff(int i);
    return m_ctrl[i][1] ? m_cnt[i] : {16'h0, m_cnt[i][15:0]};
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    int i;
    if (a < 12'h040) begin
      i = a / 32;
      case ((a % 32) / 4)
        0, 6: return m_load[i];
        1:    return m_eff(i);
        2:    return {24'h0, m_ctrl[i]};
        4:    return {31'h0, m_raw[i]};
        5:    return {31'h0, m_raw[i] & m_ctrl[i][5]};
        default: return 32'h0;
      endcase
    end
    if (a >= 12'hFE0) return {24'h0, ids[(a - 12'hFE0) / 4]};
    return 32'h0;
  endfunction

  function automatic logic m_irq();
    return (m_raw[0] & m_ctrl[0][5]) | (m_raw[1] & m_ctrl[1][5]);
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 2; i++) begin
      m_load[i] = 0; m_cnt[i] = 32'hFFFF_FFFF; m_ctrl[i] = 8'h20;
      m_raw[i] = 0; m_psc[i] = 0;
    end
  endtask

  task automatic m_step(logic [11:0] a, logic we, logic [31:0] d, logic [1:0] tk);
    for (int i = 0; i < 2; i++) begin
      bit sel, fire;
      int off, div;
      logic [31:0] eff;
      sel  = we && a < 12'h040 && (a / 32) == i;
      off  = (a % 32) / 4;
      div  = (m_ctrl[i][3:2] == 2'd1) ? 16 : (m_ctrl[i][3:2] == 2'd2) ? 256 : 1;
      eff  = m_eff(i);
      fire = 0;
      if (sel && off == 2) m_psc[i] = 0;
      else if (m_ctrl[i][7] && tk[i]) begin
        if (m_psc[i] == div - 1) begin m_psc[i] = 0; fire = 1; end
        else m_psc[i]++;
      end
      if (sel && off == 0) m_cnt[i] = d;
      else if (fire) begin
        if (eff != 0)          m_cnt[i] = eff - 1;
        else if (m_ctrl[i][0]) m_cnt[i] = eff;
        else if (m_ctrl[i][6]) m_cnt[i] = m_load[i];
        else                   m_cnt[i] = m_ctrl[i][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      end
      if (fire && eff == 1)      m_raw[i] = 1;
      else if (sel && off == 3)  m_raw[i] = 0;
      if (sel && (off == 0 || off == 6)) m_load[i] = d;
      if (sel && off == 2) m_ctrl[i] = d[7:0];
    end
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h addr=%h t=%0t", tag, act, exp, addr_i, $time);
    end
  endtask

  function automatic string tag_of(logic [11:0] a);
    if (a < 12'h020) return "R1";
    if (a < 12'h040) return "R2";
    if (a >= 12'hFE0) return "R3";
    return "R4";
  endfunction

  // drive at negedge, compare before the edge, advance model at the edge
  task automatic cyc(logic [11:0] a, logic we, logic [31:0] d, logic [1:0] tk);
    addr_i = a; wr_en_i = we; wdata_i = d; tick_i = tk;
    #2;
    chk(rdata_o === m_read(a), tag_of(a), rdata_o, m_read(a));
    chk(irq_o === m_irq(), "R5", {31'h0, irq_o}, {31'h0, m_irq()});
    @(posedge clk_i);
    m_step(a, we, d, tk);
    @(negedge clk_i);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    cyc(a, 1'b1, d, 2'b00);
  endtask

  task automatic ticks(int n, logic [1:0] tk);
    for (int k = 0; k < n; k++) cyc(12'h000, 1'b0, 32'h0, tk);
  endtask

  task automatic rd_exp(logic [11:0] a, logic [31:0] exp, string tag);
    addr_i = a; wr_en_i = 0; tick_i = 0;
    #2;
    chk(rdata_o === exp, tag, rdata_o, exp);
    @(negedge clk_i);
    cyc(a, 1'b0, 32'h0, 2'b00);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 reset state
    rd_exp(12'h008, 32'h20, "R10");
    rd_exp(12'h004, 32'hFFFF, "R10");
    rd_exp(12'h028, 32'h20, "R10");
    rd_exp(12'h000, 32'h0, "R10");
    rd_exp(12'h030, 32'h0, "R10");
    chk(irq_o === 1'b0, "R10", {31'h0, irq_o}, 32'h0);

    // R3 identification table
    for (int k = 0; k < 8; k++) rd_exp(12'hFE0 + 12'(4 * k), {24'h0, ids[k]}, "R3");
    // R4 test and unmapped addresses
    rd_exp(12'hF00, 32'h0, "R4");
    rd_exp(12'hF04, 32'h0, "R4");
    rd_exp(12'h040, 32'h0, "R4");
    rd_exp(12'h800, 32'h0, "R4");
    rd_exp(12'hFDC, 32'h0, "R4");

    // R9 periodic 32-bit timer 0, div 1, IE
    wr(12'h000, 32'd3);
    wr(12'h008, 32'hE2);
    ticks(3, 2'b01);
    rd_exp(12'h004, 32'd0, "R9");
    rd_exp(12'h010, 32'd1, "R9");
    chk(irq_o === 1'b1, "R5", {31'h0, irq_o}, 32'h1);
    ticks(1, 2'b01);
    rd_exp(12'h004, 32'd3, "R9");

    // R7 timer 1 ticks leave timer 0 unchanged
    ticks(5, 2'b10);
    rd_exp(12'h004, 32'd3, "R7");
    rd_exp(12'h024, 32'hFFFF, "R7");

    // R8 clear; R5 masking
    wr(12'h00C, 32'h0);
    rd_exp(12'h010, 32'd0, "R8");
    ticks(4, 2'b01);
    wr(12'h008, 32'hC2);
    rd_exp(12'h010, 32'd1, "R5");
    rd_exp(12'h014, 32'd0, "R5");
    chk(irq_o === 1'b0, "R5", {31'h0, irq_o}, 32'h0);

    // R7 / R9 timer 1 free-running 16-bit, div 16
    wr(12'h020, 32'd2);
    wr(12'h028, 32'h84);
    ticks(16, 2'b10);
    rd_exp(12'h024, 32'd1, "R7");
    ticks(15, 2'b10);
    rd_exp(12'h024, 32'd1, "R7");
    ticks(1, 2'b10);
    rd_exp(12'h030, 32'd1, "R9");
    ticks(16, 2'b10);
    rd_exp(12'h024, 32'hFFFF, "R9");

    // R9 one-shot timer 0 holds at zero
    wr(12'h00C, 32'h0);
    wr(12'h000, 32'd2);
    wr(12'h008, 32'hA3);
    ticks(5, 2'b01);
    rd_exp(12'h004, 32'd0, "R9");
    rd_exp(12'h010, 32'd1, "R9");

    // R8 reload-only write and ignored count write
    wr(12'h018, 32'd7);
    rd_exp(12'h000, 32'd7, "R8");
    rd_exp(12'h004, 32'd0, "R8");
    wr(12'h004, 32'h55);
    rd_exp(12'h004, 32'd0, "R8");
    rd_exp(12'h00C, 32'd0, "R8");

    // R9 expiry beats clear in the same cycle
    wr(12'h000, 32'd1);
    wr(12'h008, 32'hE2);
    wr(12'h00C, 32'h0);
    cyc(12'h00C, 1'b1, 32'h0, 2'b01);
    rd_exp(12'h010, 32'd1, "R9");

    // R6 writes outside timer windows
    wr(12'hFE0, 32'hFF);
    wr(12'hF00, 32'h1);
    wr(12'hF04, 32'h1);
    wr(12'h040, 32'h1234);
    wr(12'h7FC, 32'hFFFF);
    rd_exp(12'hFE0, 32'h04, "R6");
    rd_exp(12'h000, 32'd1, "R6");
    rd_exp(12'h008, 32'hE2, "R6");
    rd_exp(12'h028, 32'h84, "R6");

    // R1 / R2 routing
    wr(12'h020, 32'hABCD);
    rd_exp(12'h020, 32'hABCD, "R2");
    rd_exp(12'h000, 32'd1, "R1");
    wr(12'h038, 32'h99);
    rd_exp(12'h038, 32'h99, "R2");
    rd_exp(12'h018, 32'd1, "R1");

    // mixed traffic against the model
    for (int k = 0; k < 4000; k++) begin
      logic [11:0] a;
      logic [31:0] d;
      logic we;
      if ($urandom % 10 < 7) a = 12'(($urandom % 2) * 32 + ($urandom % 8) * 4);
      else begin
        case ($urandom % 4)
          0: a = 12'hFE0 + 12'(($urandom % 8) * 4);
          1: a = 12'hF00;
          2: a = 12'h044;
          default: a = 12'h7FC;
        endcase
      end
      we = ($urandom % 4 == 0);
      d  = ((a % 32) == 8) ? (32'h80 | ($urandom % 256)) : ($urandom % 24);
      cyc(a, we, d, 2'($urandom % 4));
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule